// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block sits beside the array controller of a NOR-style parallel flash that runs in byte mode. It watches every bus write, each carrying an address and a data byte, and recognises the multi-write command sequences. Almost every sequence starts with a fixed two-write unlock prefix. From those writes it tracks the operating mode of the device. It emits one-cycle strobes that start a chip or sector erase, suspend the running sector erase, or resume it. While the device is in identification mode, it answers reads with the manufacturer code, the device code words and per-sector protection bytes.

The bus side is a synchronous strobe interface that replaces the write-enable and chip-enable edges. The bus logic latches the address at the later falling edge and the data at the earlier rising edge, then presents them with `wr_stb` for one clock. No input is back-pressured: each write and each read strobe is taken in the cycle it is presented. Reads outside identification mode are not decoded, so `id_valid` stays low and the array answers. The array controller reports the end of an erase with `erase_done`.

Mode encoding on `mode`: 0 read, 1 identification, 2 query, 3 secure region, 4 chip erase running, 5 sector erase running, 6 erase suspended. Only the address bits [11:0] take part in matching the unlock and command writes. The sector is selected by address bits [21:15].

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0, all four strobes are low and `id_valid` is low.
- R2: The unlock prefix is AAh written with address[11:0]=AAAh, then 55h written with address[11:0]=555h. Address bits above bit 11 are ignored in these writes and in the command write that follows.
- R3: The unlock prefix followed by 90h at AAAh enters identification mode (mode 1), from read mode or from erase suspend.
- R4: In identification mode, each `rd_stb` gives `id_valid` high one cycle later. `id_data` depends on rd_addr[7:0]: 00h gives the manufacturer code, 02h/1Ch/1Eh give device words 1/2/3, and 04h gives 01h if `prot_map[rd_addr[21:15]]` is set and 00h if it is clear. Any other offset gives 00h. In every other mode `id_valid` stays low.
- R5: F0h written at any address leaves identification or query mode. The decoder returns to erase suspend (6) if identification was entered from suspend, and to read mode (0) otherwise.
- R6: Unlock, 80h at AAAh, unlock, then 10h at AAAh pulses `chip_erase_go` and sets mode 4. This is accepted only from read mode.
- R7: The same sequence ending in 30h at any address pulses `sector_erase_go`, sets mode 5, and loads `sector_idx` with address[21:15].
- R8: B0h at any address while in mode 5 pulses `erase_suspend_go` and sets mode 6. In any other mode it is ignored.
- R9: 30h at any address while in mode 6 pulses `erase_resume_go` and sets mode 5. In read mode it is ignored.
- R10: 98h with address[11:0]=0AAh enters query mode (2) from read or identification mode. In secure-region or suspend mode it is ignored.
- R11: Unlock plus 88h at AAAh, from read mode, enters the secure region (3). Unlock, 90h at AAAh, then 00h at any address returns to read mode.
- R12: A write that breaks a partial sequence discards that sequence. The mode is unchanged and no strobe is raised.
- R13: `erase_done` in mode 4 or 5 returns to read mode.
- R14: At most one strobe is high in any cycle, and each strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One bus write this cycle |
| wr_addr | input | ADDR_W | Latched write address |
| wr_data | input | 8 | Latched write data byte |
| erase_done | input | 1 | Array controller finished the erase |
| rd_stb | input | 1 | One bus read this cycle |
| rd_addr | input | ADDR_W | Read address |
| prot_map | input | 2**SECT_W | Per-sector protection flags |
| mode | output | 3 | Current device mode (encoding above) |
| chip_erase_go | output | 1 | Start chip erase |
| sector_erase_go | output | 1 | Start sector erase |
| erase_suspend_go | output | 1 | Suspend sector erase |
| erase_resume_go | output | 1 | Resume sector erase |
| sector_idx | output | SECT_W | Sector chosen by last sector erase |
| id_valid | output | 1 | `id_data` holds an identification answer |
| id_data | output | 8 | Identification/protection byte |

## Verification
Assertions check on every cycle that the strobes are mutually exclusive and single-cycle, and that suspend and resume strobes appear only on the mode transitions they belong to. They also check that the mode holds when there is no write and no erase completion, that `sector_idx` moves only with a sector-erase strobe, and that identification answers follow an identification-mode read. Only the bench scenarios can show the full sequences. These include the high-address-bit masking, the return to suspend after identification, secure-region entry and exit, rejected commands in the wrong mode, and the discarding of broken sequences.

// File: rtl/nfd_pkg.sv
`timescale 1ns/1ps
package nfd_pkg;
  typedef enum logic [2:0] {
    MD_READ   = 3'd0,
    MD_ID     = 3'd1,
    MD_CFI    = 3'd2,
    MD_SECURE = 3'd3,
    MD_CERASE = 3'd4,
    MD_SERASE = 3'd5,
    MD_SUSP   = 3'd6
  } mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_E1, SQ_E2, SQ_E3, SQ_X1
  } seq_e;

  typedef struct packed {
    logic at_aaa;
    logic at_555;
    logic at_0aa;
  } addr_hit_t;

  localparam int LO_W = 12;
  localparam logic [LO_W-1:0] A_AAA = 12'hAAA;
  localparam logic [LO_W-1:0] A_555 = 12'h555;
  localparam logic [LO_W-1:0] A_0AA = 12'h0AA;

  localparam logic [7:0] C_UNLK1  = 8'hAA;
  localparam logic [7:0] C_UNLK2  = 8'h55;
  localparam logic [7:0] C_IDENT  = 8'h90;
  localparam logic [7:0] C_RESET  = 8'hF0;
  localparam logic [7:0] C_SETUP  = 8'h80;
  localparam logic [7:0] C_CHIP   = 8'h10;
  localparam logic [7:0] C_SECT   = 8'h30;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_RESUME = 8'h30;
  localparam logic [7:0] C_QUERY  = 8'h98;
  localparam logic [7:0] C_SECURE = 8'h88;
  localparam logic [7:0] C_EXIT   = 8'h00;
endpackage

// File: rtl/nfd_addr_match.sv
`timescale 1ns/1ps
module nfd_addr_match
  import nfd_pkg::*;
(
  input  logic [LO_W-1:0] lo_addr,
  output addr_hit_t       hit
);
  always_comb begin
    hit.at_aaa = (lo_addr == A_AAA);
    hit.at_555 = (lo_addr == A_555);
    hit.at_0aa = (lo_addr == A_0AA);
  end
endmodule

// File: rtl/nfd_seq_fsm.sv
`timescale 1ns/1ps
module nfd_seq_fsm
  import nfd_pkg::*;
#(
  parameter int SECT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  addr_hit_t         hit,
  input  logic [7:0]        wr_data,
  input  logic [SECT_W-1:0] sect_addr,
  input  logic              erase_done,
  output mode_e             mode_q,
  output logic              chip_go,
  output logic              sect_go,
  output logic              susp_go,
  output logic              res_go,
  output logic [SECT_W-1:0] sect_idx
);
  seq_e              seq_q, seq_d;
  mode_e             mode_d;
  logic              bg_q, bg_d;
  logic [SECT_W-1:0] sect_d;
  logic              chip_d, sect_go_d, susp_d, res_d;

  always_comb begin
    mode_d    = mode_q;
    seq_d     = seq_q;
    bg_d      = bg_q;
    sect_d    = sect_idx;
    chip_d    = 1'b0;
    sect_go_d = 1'b0;
    susp_d    = 1'b0;
    res_d     = 1'b0;
    if (erase_done && (mode_q == MD_CERASE || mode_q == MD_SERASE)) begin
      mode_d = MD_READ;
      seq_d  = SQ_IDLE;
    end else if (wr_stb) begin
      if (seq_q != SQ_IDLE) begin
        seq_d = SQ_IDLE;  // any non-matching write drops the partial sequence
        case (seq_q)
          SQ_U1: if (hit.at_555 && wr_data == C_UNLK2) seq_d = SQ_U2;
          SQ_U2: if (hit.at_aaa) begin
            if (wr_data == C_IDENT) begin
              if (mode_q == MD_SECURE) seq_d = SQ_X1;
              else begin
                mode_d = MD_ID;
                bg_d   = (mode_q == MD_SUSP);
              end
            end else if (wr_data == C_SECURE && mode_q == MD_READ) begin
              mode_d = MD_SECURE;
            end else if (wr_data == C_SETUP && mode_q == MD_READ) begin
              seq_d = SQ_E1;
            end
          end
          SQ_E1: if (hit.at_aaa && wr_data == C_UNLK1) seq_d = SQ_E2;
          SQ_E2: if (hit.at_555 && wr_data == C_UNLK2) seq_d = SQ_E3;
          SQ_E3: begin
            if (hit.at_aaa && wr_data == C_CHIP) begin
              mode_d = MD_CERASE;
              chip_d = 1'b1;
            end else if (wr_data == C_SECT) begin
              mode_d    = MD_SERASE;
              sect_go_d = 1'b1;
              sect_d    = sect_addr;
            end
          end
          SQ_X1: if (wr_data == C_EXIT) mode_d = MD_READ;
          default: ;
        endcase
      end else begin
        case (mode_q)
          MD_READ: begin
            if (hit.at_aaa && wr_data == C_UNLK1) seq_d = SQ_U1;
            else if (hit.at_0aa && wr_data == C_QUERY) begin
              mode_d = MD_CFI;
              bg_d   = 1'b0;
            end
          end
          MD_ID: begin
            if (wr_data == C_RESET) mode_d = bg_q ? MD_SUSP : MD_READ;
            else if (hit.at_0aa && wr_data == C_QUERY) mode_d = MD_CFI;
          end
          MD_CFI: if (wr_data == C_RESET) mode_d = bg_q ? MD_SUSP : MD_READ;
          MD_SECURE: if (hit.at_aaa && wr_data == C_UNLK1) seq_d = SQ_U1;
          MD_SERASE: if (wr_data == C_SUSP) begin
            mode_d = MD_SUSP;
            susp_d = 1'b1;
          end
          MD_SUSP: begin
            if (wr_data == C_RESUME) begin
              mode_d = MD_SERASE;
              res_d  = 1'b1;
            end else if (hit.at_aaa && wr_data == C_UNLK1) seq_d = SQ_U1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_READ;
      seq_q    <= SQ_IDLE;
      bg_q     <= 1'b0;
      sect_idx <= '0;
      chip_go  <= 1'b0;
      sect_go  <= 1'b0;
      susp_go  <= 1'b0;
      res_go   <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      seq_q    <= seq_d;
      bg_q     <= bg_d;
      sect_idx <= sect_d;
      chip_go  <= chip_d;
      sect_go  <= sect_go_d;
      susp_go  <= susp_d;
      res_go   <= res_d;
    end
  end

  assert_strobe_exclusive_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chip_go, sect_go, susp_go, res_go}));
  assert_chip_single_cycle_R14: assert property (@(posedge clk) disable iff (!rst_n)
    chip_go |=> !chip_go);
  assert_chip_after_sequence_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chip_go |-> ($past(seq_q) == SQ_E3 && mode_q == MD_CERASE));
  assert_suspend_from_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    susp_go |-> ($past(mode_q) == MD_SERASE && mode_q == MD_SUSP));
  assert_resume_from_suspend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_go |-> ($past(mode_q) == MD_SUSP && mode_q == MD_SERASE));
  assert_mode_holds_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_stb) && !$past(erase_done)) |-> $stable(mode_q));
  assert_sector_idx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sect_go |-> $stable(sect_idx));
endmodule

// File: rtl/nfd_id_port.sv
`timescale 1ns/1ps
module nfd_id_port #(
  parameter int         SECT_W = 7,
  parameter logic [7:0] MFR_ID = 8'h5A,
  parameter logic [7:0] DEV_W1 = 8'h3C,
  parameter logic [7:0] DEV_W2 = 8'h21,
  parameter logic [7:0] DEV_W3 = 8'h07
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_stb,
  input  logic                   id_mode,
  input  logic [7:0]             offs,
  input  logic [SECT_W-1:0]      sect,
  input  logic [(1<<SECT_W)-1:0] prot_map,
  output logic                   id_valid,
  output logic [7:0]             id_data
);
  logic [7:0] ans;

  always_comb begin
    case (offs)
      8'h00:   ans = MFR_ID;
      8'h02:   ans = DEV_W1;
      8'h1C:   ans = DEV_W2;
      8'h1E:   ans = DEV_W3;
      8'h04:   ans = {7'd0, prot_map[sect]};
      default: ans = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_valid <= 1'b0;
      id_data  <= 8'h00;
    end else begin
      id_valid <= rd_stb && id_mode;
      if (rd_stb && id_mode) id_data <= ans;
    end
  end

  assert_id_only_in_ident_R4: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> ($past(rd_stb) && $past(id_mode)));
  assert_id_mfr_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && $past(offs) == 8'h00) |-> id_data == MFR_ID);
endmodule

// File: rtl/nor_cmd_decoder.sv
`timescale 1ns/1ps
module nor_cmd_decoder
  import nfd_pkg::*;
#(
  parameter int         ADDR_W = 22,
  parameter int         SECT_W = 7,
  parameter logic [7:0] MFR_ID = 8'h5A,
  parameter logic [7:0] DEV_W1 = 8'h3C,
  parameter logic [7:0] DEV_W2 = 8'h21,
  parameter logic [7:0] DEV_W3 = 8'h07
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_stb,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [7:0]             wr_data,
  input  logic                   erase_done,
  input  logic                   rd_stb,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [(1<<SECT_W)-1:0] prot_map,
  output logic [2:0]             mode,
  output logic                   chip_erase_go,
  output logic                   sector_erase_go,
  output logic                   erase_suspend_go,
  output logic                   erase_resume_go,
  output logic [SECT_W-1:0]      sector_idx,
  output logic                   id_valid,
  output logic [7:0]             id_data
);
  localparam int SECT_LSB = ADDR_W - SECT_W;

  addr_hit_t hit;
  mode_e     mode_q;
  logic      unused_addr_bits;

  assign unused_addr_bits = ^{wr_addr[SECT_LSB-1:LO_W], rd_addr[SECT_LSB-1:8]};

  nfd_addr_match u_match (
    .lo_addr (wr_addr[LO_W-1:0]),
    .hit     (hit)
  );

  nfd_seq_fsm #(.SECT_W(SECT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .hit        (hit),
    .wr_data    (wr_data),
    .sect_addr  (wr_addr[ADDR_W-1:SECT_LSB]),
    .erase_done (erase_done),
    .mode_q     (mode_q),
    .chip_go    (chip_erase_go),
    .sect_go    (sector_erase_go),
    .susp_go    (erase_suspend_go),
    .res_go     (erase_resume_go),
    .sect_idx   (sector_idx)
  );

  nfd_id_port #(
    .SECT_W (SECT_W),
    .MFR_ID (MFR_ID),
    .DEV_W1 (DEV_W1),
    .DEV_W2 (DEV_W2),
    .DEV_W3 (DEV_W3)
  ) u_id (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (rd_stb),
    .id_mode  (mode_q == MD_ID),
    .offs     (rd_addr[7:0]),
    .sect     (rd_addr[ADDR_W-1:SECT_LSB]),
    .prot_map (prot_map),
    .id_valid (id_valid),
    .id_data  (id_data)
  );

  assign mode = mode_q;
endmodule

// File: tb/sim_nor_cmd_decoder.sv
`timescale 1ns/1ps
module sim_nor_cmd_decoder;
  localparam int NV = 56;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_stb = 1'b0;
  logic [21:0]  wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic         erase_done = 1'b0;
  logic         rd_stb = 1'b0;
  logic [21:0]  rd_addr = '0;
  logic [127:0] prot_map = 128'h20;  // only sector 5 protected
  logic [2:0]   mode;
  logic         chip_erase_go, sector_erase_go, erase_suspend_go, erase_resume_go;
  logic [6:0]   sector_idx;
  logic         id_valid;
  logic [7:0]   id_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nor_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .erase_done(erase_done), .rd_stb(rd_stb), .rd_addr(rd_addr), .prot_map(prot_map),
    .mode(mode), .chip_erase_go(chip_erase_go), .sector_erase_go(sector_erase_go),
    .erase_suspend_go(erase_suspend_go), .erase_resume_go(erase_resume_go),
    .sector_idx(sector_idx), .id_valid(id_valid), .id_data(id_data)
  );

  // {kind(2) 0=write 1=erase_done 2=read, addr(22), data(8), exp_mode(3),
  //  exp_strobes(4) {chip,sector,suspend,resume}, exp_id_valid(1), exp_id_data(8), req(4)}
  function automatic logic [51:0] mk(input logic [1:0] k, input logic [21:0] a,
      input logic [7:0] d, input logic [2:0] m, input logic [3:0] s,
      input logic rv, input logic [7:0] rd, input logic [3:0] rq);
    return {k, a, d, m, s, rv, rd, rq};
  endfunction

  localparam logic [51:0] VEC [0:NV-1] = '{
    mk(0, 22'h000AAA, 8'hAA, 0, 0, 0, 0, 2),   // R2 unlock
    mk(0, 22'h000555, 8'h55, 0, 0, 0, 0, 2),
    mk(0, 22'h000AAA, 8'h90, 1, 0, 0, 0, 3),   // R3 identification
    mk(2, 22'h000000, 8'h00, 1, 0, 1, 8'h5A, 4), // R4 manufacturer
    mk(2, 22'h000002, 8'h00, 1, 0, 1, 8'h3C, 4),
    mk(2, 22'h00001C, 8'h00, 1, 0, 1, 8'h21, 4),
    mk(2, 22'h00001E, 8'h00, 1, 0, 1, 8'h07, 4),
    mk(2, 22'h028004, 8'h00, 1, 0, 1, 8'h01, 4), // protected sector 5
    mk(2, 22'h030004, 8'h00, 1, 0, 1, 8'h00, 4), // sector 6 open
    mk(2, 22'h000010, 8'h00, 1, 0, 1, 8'h00, 4), // other offset
    mk(0, 22'h3FF0AA, 8'h98, 2, 0, 0, 0, 10),  // R10 query from ident
    mk(0, 22'h000123, 8'hF0, 0, 0, 0, 0, 5),   // R5 back to read
    mk(2, 22'h000000, 8'h00, 0, 0, 0, 0, 4),   // no answer in read
    mk(0, 22'h3F0AAA, 8'hAA, 0, 0, 0, 0, 2),   // R2 high bits set
    mk(0, 22'h155555, 8'h55, 0, 0, 0, 0, 2),
    mk(0, 22'h2A0AAA, 8'h80, 0, 0, 0, 0, 6),
    mk(0, 22'h000AAA, 8'hAA, 0, 0, 0, 0, 6),
    mk(0, 22'h000555, 8'h55, 0, 0, 0, 0, 6),
    mk(0, 22'h000AAA, 8'h10, 4, 4'b1000, 0, 0, 6), // R6 chip erase
    mk(0, 22'h000000, 8'hB0, 4, 0, 0, 0, 8),   // R8 ignored in chip erase
    mk(1, 22'h000000, 8'h00, 0, 0, 0, 0, 13),  // R13 done
    mk(0, 22'h000000, 8'h30, 0, 0, 0, 0, 9),   // R9 ignored in read
    mk(0, 22'h000AAA, 8'hAA, 0, 0, 0, 0, 7),
    mk(0, 22'h000555, 8'h55, 0, 0, 0, 0, 7),
    mk(0, 22'h000AAA, 8'h80, 0, 0, 0, 0, 7),
    mk(0, 22'h000AAA, 8'hAA, 0, 0, 0, 0, 7),
    mk(0, 22'h000555, 8'h55, 0, 0, 0, 0, 7),
    mk(0, 22'h1D8000, 8'h30, 5, 4'b0100, 0, 0, 7), // R7 sector 3Bh
    mk(0, 22'h000000, 8'h00, 5, 0, 0, 0, 12),
    mk(0, 22'h012345, 8'hB0, 6, 4'b0010, 0, 0, 8), // R8 suspend
    mk(0, 22'h0000AA, 8'h98, 6, 0, 0, 0, 10),  // R10 ignored in suspend
    mk(0, 22'h000AAA, 8'hAA, 6, 0, 0, 0, 3),
    mk(0, 22'h000555, 8'h55, 6, 0, 0, 0, 3),
    mk(0, 22'h000AAA, 8'h90, 1, 0, 0, 0, 3),   // R3 ident from suspend
    mk(2, 22'h000000, 8'h00, 1, 0, 1, 8'h5A, 4),
    mk(0, 22'h000000, 8'hF0, 6, 0, 0, 0, 5),   // R5 back to suspend
    mk(0, 22'h000777, 8'h30, 5, 4'b0001, 0, 0, 9), // R9 resume
    mk(1, 22'h000000, 8'h00, 0, 0, 0, 0, 13),
    mk(0, 22'h000AAA, 8'hAA, 0, 0, 0, 0, 11),
    mk(0, 22'h000555, 8'h55, 0, 0, 0, 0, 11),
    mk(0, 22'h000AAA, 8'h88, 3, 0, 0, 0, 11),  // R11 secure enter
    mk(0, 22'h0000AA, 8'h98, 3, 0, 0, 0, 10),  // R10 ignored in secure
    mk(0, 22'h000AAA, 8'hAA, 3, 0, 0, 0, 11),
    mk(0, 22'h000555, 8'h55, 3, 0, 0, 0, 11),
    mk(0, 22'h000AAA, 8'h90, 3, 0, 0, 0, 11),
    mk(0, 22'h000321, 8'h00, 0, 0, 0, 0, 11),  // R11 secure exit
    mk(0, 22'h000AAA, 8'hAA, 0, 0, 0, 0, 12),
    mk(0, 22'h000554, 8'h55, 0, 0, 0, 0, 12),  // R12 wrong address breaks
    mk(0, 22'h000AAA, 8'h90, 0, 0, 0, 0, 12),
    mk(0, 22'h000AAA, 8'hAA, 0, 0, 0, 0, 12),
    mk(0, 22'h000555, 8'h55, 0, 0, 0, 0, 12),
    mk(0, 22'h000AAA, 8'h80, 0, 0, 0, 0, 12),
    mk(0, 22'h000AAA, 8'hAA, 0, 0, 0, 0, 12),
    mk(0, 22'h000555, 8'h12, 0, 0, 0, 0, 12),  // wrong data breaks
    mk(0, 22'h000AAA, 8'h10, 0, 0, 0, 0, 12),
    mk(0, 22'h0000AA, 8'h98, 2, 0, 0, 0, 10)   // R10 query from read
  };

  task automatic chk(input bit ok, input int rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [21:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd(input logic [21:0] a);
    @(negedge clk);
    rd_stb = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic unlock();
    wr(22'h000AAA, 8'hAA);
    wr(22'h000555, 8'h55);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mode == 3'd0, 1, "mode", mode, 0);
    chk({chip_erase_go, sector_erase_go, erase_suspend_go, erase_resume_go} == 4'b0, 1,
        "strobes", {chip_erase_go, sector_erase_go, erase_suspend_go, erase_resume_go}, 0);
    chk(id_valid == 1'b0, 1, "id_valid", id_valid, 0);

    for (int i = 0; i < NV; i++) begin
      logic [51:0] e;
      logic [3:0]  stb;
      e = VEC[i];
      @(negedge clk);
      case (e[51:50])
        2'd0: begin wr_stb = 1'b1; wr_addr = e[49:28]; wr_data = e[27:20]; end
        2'd1: erase_done = 1'b1;
        default: begin rd_stb = 1'b1; rd_addr = e[49:28]; end
      endcase
      @(negedge clk);
      wr_stb = 1'b0; erase_done = 1'b0; rd_stb = 1'b0;
      stb = {chip_erase_go, sector_erase_go, erase_suspend_go, erase_resume_go};
      chk(mode == e[19:17], int'(e[3:0]), $sformatf("mode step %0d", i), mode, e[19:17]);
      chk(stb == e[16:13], int'(e[3:0]), $sformatf("strobes step %0d", i), stb, e[16:13]);
      chk(id_valid == e[12], int'(e[3:0]), $sformatf("id_valid step %0d", i), id_valid, e[12]);
      if (e[12])
        chk(id_data == e[11:4], int'(e[3:0]), $sformatf("id_data step %0d", i), id_data, e[11:4]);
    end
    // R7 sector index from the sector erase at 1D8000h
    chk(sector_idx == 7'h3B, 7, "sector_idx", sector_idx, 7'h3B);

    // leave query mode
    wr(22'h000000, 8'hF0);
    chk(mode == 3'd0, 5, "mode after F0", mode, 0);

    // R14 strobe lasts one cycle
    unlock(); wr(22'h000AAA, 8'h80); unlock();
    wr(22'h000AAA, 8'h10);
    chk(chip_erase_go == 1'b1, 14, "chip go first cycle", chip_erase_go, 1);
    @(negedge clk);
    chk(chip_erase_go == 1'b0, 14, "chip go second cycle", chip_erase_go, 0);
    chk(mode == 3'd4, 6, "mode chip erase", mode, 4);
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    chk(mode == 3'd0, 13, "mode after done", mode, 0);

    // R1 reset while in identification mode
    unlock(); wr(22'h000AAA, 8'h90);
    chk(mode == 3'd1, 3, "mode ident", mode, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(mode == 3'd0, 1, "mode after reset", mode, 0);
    rd(22'h000000);
    chk(id_valid == 1'b0, 1, "id_valid after reset", id_valid, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule